// File: doc/BRIEF.md
# S/PDIF Biphase-Mark Frame Transmitter

This block turns parallel stereo samples into a serial S/PDIF line signal. Each stereo frame carries two sub-frames, channel A (left) then channel B (right). A sub-frame has 32 slots: a 4-slot sync pattern, 24 sample bits sent least significant bit first, then a validity flag, a user bit, a channel-status bit and an even-parity bit. The finished sub-frame is biphase-mark coded onto `line_o`. The block runs from a clock at twice the bit rate, so every clock cycle produces one half-bit.

A frame counter groups frames into blocks of `FRAMES_PER_BLOCK`. The block's first sub-frame gets a distinct sync pattern. The frame counter also selects which channel-status bit goes out in each frame. Channel status is written as a whole block into a staging register and takes effect only at the next block boundary. Samples arrive through a valid/ready handshake, once per frame. When no sample is offered, the previous sample is sent again and marked invalid.

Top module: `spdif_tx`

## Requirements
- R1: While `rst_ni` is low, `line_o` and `smp_ready_o` are 0. After release, the first sub-frame carries the block-start sync pattern. The first frame carries sample value 0 with both validity bits set to 1 and channel-status bit 0.
- R2: Each sub-frame lasts 64 clock cycles (32 slots of two half-bits), and a frame lasts 128 cycles. `smp_ready_o` is high for exactly one cycle per frame, which is the last cycle of the frame, so consecutive pulses are 128 cycles apart.
- R3: Slots 0 to 3 hold an 8-half-bit sync pattern, sent first half-bit first: 11101000 on the channel-A sub-frame of frame 0 of each block, 11100010 on every other channel-A sub-frame, and 11100100 on every channel-B sub-frame. A pattern is inverted when the line level before it is 1.
- R4: Slots 4 to 27 carry sample bits 0 to 23 in ascending order. Slots 4 to 7 hold bits 3:0.
- R5: Slot 28 carries the sub-frame's invalid flag, where 1 means invalid. Slot 29, the user bit, is always 0.
- R6: Slot 31 is set so that slots 4 to 31 contain an even number of ones. As a result, every sub-frame ends with the line at the level it had before the sync pattern.
- R7: Biphase-mark coding: in slots 4 to 31 the level toggles at the start of every slot, and toggles again mid-slot when the bit is 1.
- R8: A sample offered with `smp_valid_i` high during the `smp_ready_o` cycle is taken at that clock edge. It is sent in the following frame, with `smp_left_i` in channel A and `smp_right_i` in channel B, each with its own invalid flag.
- R9: If `smp_valid_i` is low during the `smp_ready_o` cycle, the next frame repeats the last accepted sample values with both invalid flags set to 1.
- R10: Slot 30 of both sub-frames of frame f of a block carries bit f of the active channel-status register.
- R11: A `cs_load_i` pulse writes `cs_bits_i` into a staging register. The active register takes the staged value only at the end of the last frame of a block, so a load during a block leaves that block's channel-status bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Half-bit clock (twice the bit rate) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| smp_valid_i | input | 1 | Sample pair offered |
| smp_ready_o | output | 1 | Sample pair taken this cycle when valid |
| smp_left_i | input | 24 | Channel-A sample |
| smp_right_i | input | 24 | Channel-B sample |
| inval_left_i | input | 1 | Channel-A sample invalid |
| inval_right_i | input | 1 | Channel-B sample invalid |
| cs_load_i | input | 1 | Write staging channel-status register |
| cs_bits_i | input | FRAMES_PER_BLOCK | Channel-status block, bit f for frame f |
| line_o | output | 1 | Biphase-mark coded line |

## Verification
The bench builds the block with `FRAMES_PER_BLOCK` set to 4, which makes a block only 512 cycles long. Within about a dozen frames the bench therefore sees three block-start sync patterns, two staging-to-active channel-status transfers, and a load made in the middle of a block. The bench decodes the line half-bit by half-bit with its own model. This covers sync-pattern choice, sample bit order, parity, repeated-and-invalid frames, and a reset applied mid-stream.

// File: rtl/spdif_tx_pkg.sv
package spdif_tx_pkg;
  localparam int SAMPLE_W  = 24;
  localparam int SLOT_N    = 32;
  localparam int SLOT_W    = $clog2(SLOT_N);
  localparam int SYNC_SLOTS = 4;
  localparam int DATA_LO   = SYNC_SLOTS;
  localparam int VAL_SLOT  = DATA_LO + SAMPLE_W;
  localparam int USR_SLOT  = VAL_SLOT + 1;
  localparam int CS_SLOT   = USR_SLOT + 1;
  localparam int PAR_SLOT  = CS_SLOT + 1;

  // sync patterns, MSB is the first half-bit, for a preceding low level
  localparam logic [7:0] SYNC_BLK = 8'b1110_1000;
  localparam logic [7:0] SYNC_A   = 8'b1110_0010;
  localparam logic [7:0] SYNC_B   = 8'b1110_0100;

  typedef struct packed {
    logic [SAMPLE_W-1:0] data;
    logic                inval;
  } chan_t;
endpackage

// File: rtl/spdif_tx_seq.sv
module spdif_tx_seq #(
  parameter int FRAMES = 192,
  parameter int FW     = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  output logic                           half_o,
  output logic [spdif_tx_pkg::SLOT_W-1:0] slot_o,
  output logic                           sub_o,
  output logic [FW-1:0]                  frame_o,
  output logic                           frame_end_o,
  output logic                           block_end_o,
  output logic                           block_first_o
);
  import spdif_tx_pkg::*;

  localparam logic [FW-1:0]     LAST_FRAME = FW'(FRAMES - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT  = SLOT_W'(SLOT_N - 1);

  logic              half_q;
  logic [SLOT_W-1:0] slot_q;
  logic              sub_q;
  logic [FW-1:0]     frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q  <= 1'b0;
      slot_q  <= '0;
      sub_q   <= 1'b0;
      frame_q <= '0;
    end else begin
      half_q <= ~half_q;
      if (half_q) begin
        slot_q <= slot_q + 1'b1;
        if (slot_q == LAST_SLOT) begin
          sub_q <= ~sub_q;
          if (sub_q) frame_q <= (frame_q == LAST_FRAME) ? '0 : frame_q + 1'b1;
        end
      end
    end
  end

  assign half_o        = half_q;
  assign slot_o        = slot_q;
  assign sub_o         = sub_q;
  assign frame_o       = frame_q;
  assign frame_end_o   = half_q & sub_q & (slot_q == LAST_SLOT);
  assign block_end_o   = frame_end_o & (frame_q == LAST_FRAME);
  assign block_first_o = (frame_q == '0);
endmodule

// File: rtl/spdif_tx_src.sv
module spdif_tx_src (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              frame_end_i,
  input  logic                              valid_i,
  input  logic [spdif_tx_pkg::SAMPLE_W-1:0] left_i,
  input  logic [spdif_tx_pkg::SAMPLE_W-1:0] right_i,
  input  logic                              inval_left_i,
  input  logic                              inval_right_i,
  output logic                              ready_o,
  output spdif_tx_pkg::chan_t               chan_a_o,
  output spdif_tx_pkg::chan_t               chan_b_o
);
  import spdif_tx_pkg::*;

  chan_t [1:0] in_c;
  chan_t [1:0] hold_q;
  logic        take;

  assign in_c[0] = '{data: left_i,  inval: inval_left_i};
  assign in_c[1] = '{data: right_i, inval: inval_right_i};
  assign ready_o = frame_end_i;
  assign take    = frame_end_i & valid_i;

  for (genvar c = 0; c < 2; c++) begin : g_chan
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hold_q[c].data  <= '0;
        hold_q[c].inval <= 1'b1;
      end else if (take) begin
        hold_q[c] <= in_c[c];
      end else if (frame_end_i) begin
        hold_q[c].inval <= 1'b1;  // starved: repeat, flagged invalid
      end
    end
  end

  assign chan_a_o = hold_q[0];
  assign chan_b_o = hold_q[1];
endmodule

// File: rtl/spdif_tx_cs.sv
module spdif_tx_cs #(
  parameter int FRAMES = 192,
  parameter int FW     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [FRAMES-1:0] bits_i,
  input  logic              block_end_i,
  input  logic [FW-1:0]     frame_i,
  output logic              cs_bit_o
);
  logic [FRAMES-1:0] stage_q;
  logic [FRAMES-1:0] active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q  <= '0;
      active_q <= '0;
    end else begin
      if (load_i)      stage_q  <= bits_i;
      if (block_end_i) active_q <= stage_q;
    end
  end

  assign cs_bit_o = active_q[frame_i];
endmodule

// File: rtl/spdif_tx_fmt.sv
module spdif_tx_fmt (
  input  logic                            sub_i,
  input  logic                            block_first_i,
  input  logic [spdif_tx_pkg::SLOT_W-1:0] slot_i,
  input  spdif_tx_pkg::chan_t             chan_a_i,
  input  spdif_tx_pkg::chan_t             chan_b_i,
  input  logic                            cs_bit_i,
  output logic                            slot_bit_o,
  output logic [7:0]                      sync_o
);
  import spdif_tx_pkg::*;

  chan_t             cur;
  logic [SLOT_N-1:0] word;

  assign cur = sub_i ? chan_b_i : chan_a_i;

  always_comb begin
    word                          = '0;
    word[DATA_LO +: SAMPLE_W]     = cur.data;
    word[VAL_SLOT]                = cur.inval;
    word[USR_SLOT]                = 1'b0;
    word[CS_SLOT]                 = cs_bit_i;
    word[PAR_SLOT]                = ^word[CS_SLOT:DATA_LO];
  end

  always_comb begin
    if (sub_i)              sync_o = SYNC_B;
    else if (block_first_i) sync_o = SYNC_BLK;
    else                    sync_o = SYNC_A;
  end

  assign slot_bit_o = word[slot_i];
endmodule

// File: rtl/spdif_tx_bmc.sv
module spdif_tx_bmc (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            half_i,
  input  logic [spdif_tx_pkg::SLOT_W-1:0] slot_i,
  input  logic                            slot_bit_i,
  input  logic [7:0]                      sync_i,
  output logic                            line_o
);
  import spdif_tx_pkg::*;

  logic       line_q, line_d;
  logic       inv_q, inv_now;
  logic       sync_start;
  logic [2:0] idx;

  assign sync_start = (slot_i == '0) & ~half_i;
  assign inv_now    = sync_start ? line_q : inv_q;
  assign idx        = {slot_i[1:0], half_i};

  always_comb begin
    if (slot_i < SLOT_W'(SYNC_SLOTS)) line_d = sync_i[3'd7 - idx] ^ inv_now;
    else if (!half_i)                line_d = ~line_q;
    else                             line_d = line_q ^ slot_bit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= 1'b0;
      inv_q  <= 1'b0;
    end else begin
      line_q <= line_d;
      if (sync_start) inv_q <= line_q;
    end
  end

  assign line_o = line_q;
endmodule

// File: rtl/spdif_tx.sv
module spdif_tx #(
  parameter int FRAMES_PER_BLOCK = 192
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        smp_valid_i,
  output logic                        smp_ready_o,
  input  logic [23:0]                 smp_left_i,
  input  logic [23:0]                 smp_right_i,
  input  logic                        inval_left_i,
  input  logic                        inval_right_i,
  input  logic                        cs_load_i,
  input  logic [FRAMES_PER_BLOCK-1:0] cs_bits_i,
  output logic                        line_o
);
  import spdif_tx_pkg::*;

  localparam int FW = (FRAMES_PER_BLOCK > 1) ? $clog2(FRAMES_PER_BLOCK) : 1;

  logic              half;
  logic [SLOT_W-1:0] slot;
  logic              sub;
  logic [FW-1:0]     frame;
  logic              frame_end, block_end, block_first;
  chan_t             chan_a, chan_b;
  logic              cs_bit, slot_bit;
  logic [7:0]        sync;

  spdif_tx_seq #(.FRAMES(FRAMES_PER_BLOCK), .FW(FW)) u_seq (
    .clk_i, .rst_ni,
    .half_o(half), .slot_o(slot), .sub_o(sub), .frame_o(frame),
    .frame_end_o(frame_end), .block_end_o(block_end), .block_first_o(block_first)
  );

  spdif_tx_src u_src (
    .clk_i, .rst_ni,
    .frame_end_i(frame_end), .valid_i(smp_valid_i),
    .left_i(smp_left_i), .right_i(smp_right_i),
    .inval_left_i, .inval_right_i,
    .ready_o(smp_ready_o), .chan_a_o(chan_a), .chan_b_o(chan_b)
  );

  spdif_tx_cs #(.FRAMES(FRAMES_PER_BLOCK), .FW(FW)) u_cs (
    .clk_i, .rst_ni,
    .load_i(cs_load_i), .bits_i(cs_bits_i), .block_end_i(block_end),
    .frame_i(frame), .cs_bit_o(cs_bit)
  );

  spdif_tx_fmt u_fmt (
    .sub_i(sub), .block_first_i(block_first), .slot_i(slot),
    .chan_a_i(chan_a), .chan_b_i(chan_b), .cs_bit_i(cs_bit),
    .slot_bit_o(slot_bit), .sync_o(sync)
  );

  spdif_tx_bmc u_bmc (
    .clk_i, .rst_ni,
    .half_i(half), .slot_i(slot), .slot_bit_i(slot_bit), .sync_i(sync),
    .line_o(line_o)
  );
endmodule

// File: rtl/spdif_tx_chk.sv
module spdif_tx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       line_i,
  input logic       ready_i,
  input logic       half_i,
  input logic       sub_i,
  input logic [4:0] slot_i
);
  // R2
  ready_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i |=> !ready_i);

  // R8
  ready_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i |-> (half_i && sub_i && slot_i == 5'd31));

  // R7
  bmc_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i >= 5'd4 && !half_i) |=> (line_i != $past(line_i)));

  // R5
  user_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i == 5'd29 && half_i) |=> (line_i == $past(line_i)));

  // R6
  sub_end_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i == 5'd0 && !half_i) |-> !line_i);
endmodule

bind spdif_tx spdif_tx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .line_i(line_o), .ready_i(smp_ready_o),
  .half_i(half), .sub_i(sub), .slot_i(slot)
);

// File: tb/sim_spdif_tx.sv
module sim_spdif_tx;
  localparam int FPB  = 4;
  localparam int NV   = 10;
  localparam int MAXF = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic smp_valid_i = 1'b0;
  logic smp_ready_o;
  logic [23:0] smp_left_i = '0, smp_right_i = '0;
  logic inval_left_i = 1'b0, inval_right_i = 1'b0;
  logic cs_load_i = 1'b0;
  logic [FPB-1:0] cs_bits_i = '0;
  logic line_o;

  always #2.5ns clk = ~clk;

  spdif_tx #(.FRAMES_PER_BLOCK(FPB)) u0 (
    .clk_i(clk), .rst_ni, .smp_valid_i, .smp_ready_o, .smp_left_i, .smp_right_i,
    .inval_left_i, .inval_right_i, .cs_load_i, .cs_bits_i, .line_o
  );

  // {present, inval_l, inval_r, left, right}
  localparam logic [50:0] VEC [NV] = '{
    {3'b100, 24'h123456, 24'hABCDEF},
    {3'b101, 24'hFFFFFF, 24'h000000},
    {3'b000, 24'h555555, 24'hAAAAAA},
    {3'b110, 24'h800001, 24'h7FFFFE},
    {3'b100, 24'h00000F, 24'hF00000},
    {3'b000, 24'h111111, 24'h222222},
    {3'b100, 24'hA5A5A5, 24'h5A5A5A},
    {3'b100, 24'h000001, 24'h800000},
    {3'b000, 24'h333333, 24'h444444},
    {3'b111, 24'h0F0F0F, 24'hF0F0F0}
  };

  int n_chk = 0, n_err = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // line decoder, independent of the design
  logic       armed = 1'b0;
  logic       h [128];
  int         hcnt = 0, fcnt = 0;
  logic       lvl_prev = 1'b0;
  logic [7:0]  d_sync [MAXF][2];
  logic [31:0] d_word [MAXF][2];
  logic        d_prev [MAXF][2];
  logic        d_bad  [MAXF];

  always @(posedge clk) begin
    cyc++;
    armed <= rst_ni;
  end

  always @(negedge clk) begin
    if (!rst_ni) begin
      hcnt = 0; fcnt = 0; lvl_prev = 1'b0;
    end else if (armed) begin
      h[hcnt] = line_o;
      if (hcnt == 127) begin
        if (fcnt < MAXF) begin
          d_bad[fcnt] = 1'b0;
          for (int s = 0; s < 2; s++) begin
            int b;
            logic [7:0] sy;
            logic [31:0] w;
            b = s * 64;
            d_prev[fcnt][s] = (s == 0) ? lvl_prev : h[63];
            for (int j = 0; j < 8; j++) sy[7-j] = h[b+j];
            w = '0;
            for (int k = 4; k < 32; k++) begin
              w[k] = h[b+2*k] ^ h[b+2*k+1];
              if (h[b+2*k] == h[b+2*k-1]) d_bad[fcnt] = 1'b1;
            end
            d_sync[fcnt][s] = sy;
            d_word[fcnt][s] = w;
          end
        end
        lvl_prev = h[127];
        fcnt++;
        hcnt = 0;
      end else begin
        hcnt++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  logic [23:0] exp_d [MAXF][2];
  logic        exp_v [MAXF][2];

  function automatic logic exp_cs(input int f);
    int blk = f / FPB;
    logic [FPB-1:0] a;
    a = (blk == 0) ? 4'b0000 : (blk == 1) ? 4'b0110 : 4'b1001;
    return a[f % FPB];
  endfunction

  task automatic check_frame(input int f, input string tag);
    logic [7:0] ea;
    ea = ((f % FPB) == 0) ? 8'b1110_1000 : 8'b1110_0010;
    // R3 sync choice and inversion
    chk(d_sync[f][0] == (ea ^ {8{d_prev[f][0]}}), {"R3 syncA ", tag}, 32'(d_sync[f][0]), 32'(ea));
    chk(d_sync[f][1] == (8'b1110_0100 ^ {8{d_prev[f][1]}}), {"R3 syncB ", tag}, 32'(d_sync[f][1]), 32'h0E4);
    // R7 boundary toggles
    chk(!d_bad[f], {"R7 bmc ", tag}, 32'(d_bad[f]), 32'h0);
    for (int s = 0; s < 2; s++) begin
      // R4 / R8 / R9 sample bits
      chk(d_word[f][s][27:4] == exp_d[f][s], {"R4 data ", tag}, 32'(d_word[f][s][27:4]), 32'(exp_d[f][s]));
      // R5 validity and user
      chk(d_word[f][s][28] == exp_v[f][s], {"R5 valid ", tag}, 32'(d_word[f][s][28]), 32'(exp_v[f][s]));
      chk(d_word[f][s][29] == 1'b0, {"R5 user ", tag}, 32'(d_word[f][s][29]), 32'h0);
      // R10 / R11 channel status
      chk(d_word[f][s][30] == exp_cs(f), {"R10 cs ", tag}, 32'(d_word[f][s][30]), 32'(exp_cs(f)));
      // R6 parity
      chk(^d_word[f][s][31:4] == 1'b0, {"R6 parity ", tag}, d_word[f][s], 32'h0);
    end
  endtask

  initial begin
    int last_rdy;
    last_rdy = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(line_o == 1'b0, "R1 line in reset", 32'(line_o), 32'h0);
    chk(smp_ready_o == 1'b0, "R1 ready in reset", 32'(smp_ready_o), 32'h0);
    rst_ni = 1'b1;
    cs_bits_i = 4'b0110;
    cs_load_i = 1'b1;
    @(negedge clk);
    cs_load_i = 1'b0;

    exp_d[0][0] = '0; exp_d[0][1] = '0; exp_v[0][0] = 1'b1; exp_v[0][1] = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic [50:0] v;
      v = VEC[i];
      if (v[50]) begin
        exp_d[i+1][0] = v[47:24]; exp_d[i+1][1] = v[23:0];
        exp_v[i+1][0] = v[49];    exp_v[i+1][1] = v[48];
      end else begin
        exp_d[i+1][0] = exp_d[i][0]; exp_d[i+1][1] = exp_d[i][1];
        exp_v[i+1][0] = 1'b1;        exp_v[i+1][1] = 1'b1;
      end
      smp_valid_i   = v[50];
      inval_left_i  = v[49];
      inval_right_i = v[48];
      smp_left_i    = v[47:24];
      smp_right_i   = v[23:0];
      while (!smp_ready_o) @(negedge clk);
      // R2 frame period
      if (i > 0) chk(cyc - last_rdy == 128, "R2 ready period", 32'(cyc - last_rdy), 32'd128);
      last_rdy = cyc;
      @(negedge clk);
      chk(smp_ready_o == 1'b0, "R2 ready one cycle", 32'(smp_ready_o), 32'h0);
      smp_valid_i = 1'b0;
      smp_left_i  = 24'hDEAD00;
      smp_right_i = 24'h00BEEF;
      if (i == 5) begin
        // R11 mid-block load, visible from the next block only
        cs_bits_i = 4'b1001;
        cs_load_i = 1'b1;
        @(negedge clk);
        cs_load_i = 1'b0;
        cs_bits_i = 4'b1111;
      end
    end
    while (fcnt < NV + 1) @(negedge clk);
    for (int f = 0; f <= NV; f++) check_frame(f, $sformatf("frame %0d", f));

    // R1 reset in mid-stream
    rst_ni = 1'b0;
    @(negedge clk);
    chk(line_o == 1'b0, "R1 line after reset", 32'(line_o), 32'h0);
    chk(smp_ready_o == 1'b0, "R1 ready after reset", 32'(smp_ready_o), 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    while (fcnt < 1) @(negedge clk);
    chk(d_sync[0][0] == 8'b1110_1000, "R1 block sync after reset", 32'(d_sync[0][0]), 32'h0E8);
    chk(d_word[0][0][28] && d_word[0][1][28], "R1 invalid after reset",
        32'({d_word[0][0][28], d_word[0][1][28]}), 32'h3);
    chk(d_word[0][0][27:4] == 24'h0 && d_word[0][1][27:4] == 24'h0, "R1 zero data after reset",
        {4'h0, d_word[0][0][27:4]}, 32'h0);
    chk(d_word[0][0][30] == 1'b0, "R1 cs cleared after reset", 32'(d_word[0][0][30]), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule